// File: doc/BRIEF.md
# Programmable Serial Audio Transmitter

This block turns a stream of 32-bit samples into a synchronous serial audio link. It produces a bit clock, a frame sync and a serial data line. Samples are queued in a 32-entry FIFO that software or a DMA engine fills through a small register interface. The bit clock is derived from a master clock enable supplied by the surrounding chip. Every part of the frame layout is set by registers: the number of words, the width of the first word and of the other words, the sync pulse length, the first bit taken from each sample, and the shift direction.

A DMA request is raised whenever the FIFO has drained to a programmed level. If the shifter needs a sample and the FIFO is empty, it sends a zero word in that slot and keeps the frame running. It also latches an error flag, which can drive an interrupt. The clock, frame and word registers are frozen while the transmitter is enabled, so the link is always set up with the transmitter stopped.

Top module: `serial_audio_tx`

## Requirements
- R1: The bit clock period is (DIV+1)*2 cycles in which `mclk_en` is high (DIV = CLK register bits [7:0]). While idle, `bclk_o` sits at the polarity bit (CLK bit 8). Data and frame sync change on the bit clock edge that returns the clock to its idle level.
- R2: A frame has FRAME[4:0]+1 words. Word 0 carries WORD[4:0]+1 bits and every later word carries WORD[12:8]+1 bits.
- R3: Frame sync is active for FRAME[12:8]+1 bit clocks, starting with the first bit of each frame. It is active high, or active low when FRAME bit 17 is set.
- R4: When FRAME bit 16 is set, the frame sync window moves one bit clock earlier, so it starts on the last bit of the previous frame.
- R5: Each word begins at sample bit WORD[20:16]. With FRAME bit 18 set the bit index steps down on each bit; with it clear the index steps up. The index wraps modulo 32.
- R6: A write to the DATA register (address 4) pushes one 32-bit sample into a FIFO of 32 entries. A push into a full FIFO is dropped. Reading address 4 returns the fill level.
- R7: `dma_req_o` is high one cycle after the FIFO level is at or below the watermark FRAME[28:24] while CTRL bit 1 is set.
- R8: Writes to CLK (1), FRAME (2) and WORD (3) are ignored while the transmitter enable (CTRL bit 0) is set.
- R9: If a word must start while the FIFO is empty, that word is sent as zeros, frame timing is unchanged, and the error flag (CTRL bit 3) is set.
- R10: The error flag is cleared only by writing 1 to CTRL bit 3. `irq_o` follows the error flag AND the interrupt enable (CTRL bit 2), one cycle later.
- R11: With the enable clear, `sd_o` is 0, `fs_o` is inactive, `bclk_o` is idle, and the FIFO keeps its contents.
- R12: After reset, all registers read zero and `bclk_o`, `fs_o`, `sd_o`, `dma_req_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Master clock enable pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 CTRL, 1 CLK, 2 FRAME, 3 WORD, 4 DATA) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| dma_req_o | output | 1 | FIFO refill request |
| irq_o | output | 1 | Underrun interrupt |

## Verification
The hardest situation to reach is an underrun in the middle of a frame, because the FIFO has to run dry at a word boundary while the frame counters are still running. The bench loads a single sample and enables the transmitter with short 8-bit words. The second word of the first frame then starts from an empty FIFO. The bench captures two complete frames and checks the zero words, the unchanged sync pattern and the latched flag. Early sync with a frame that wraps is covered by a second stream whose first word is wider than the others.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int SAMPLE_W = 32;
  localparam int BIDX_W   = $clog2(SAMPLE_W);
  localparam int FLD_W    = 5;
  localparam int DIV_W    = 8;
  localparam int REG_W    = 32;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_CLK   = 3'd1,
    REG_FRAME = 3'd2,
    REG_WORD  = 3'd3,
    REG_DATA  = 3'd4
  } reg_addr_t;

  typedef struct packed {
    logic [FLD_W-1:0] words_m1;
    logic [FLD_W-1:0] sync_m1;
    logic [FLD_W-1:0] w0_m1;
    logic [FLD_W-1:0] wn_m1;
    logic [FLD_W-1:0] first_bit;
    logic             early;
    logic             msb_first;
  } frame_cfg_t;
endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sat_bitclk.sv
module sat_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             mclk_en,
  input  logic [DIV_W-1:0] div,
  output logic             phase,
  output logic             drive_tick
);
  logic [DIV_W-1:0] cnt;
  logic             half_done;

  assign half_done  = mclk_en && (cnt == div);
  // the drive edge is the one that returns the clock to its idle phase
  assign drive_tick = run && half_done && phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (mclk_en) begin
      if (half_done) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_framer.sv
module sat_framer
  import sat_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                tick,
  input  frame_cfg_t          cfg,
  input  logic [SAMPLE_W-1:0] fifo_dout,
  input  logic                fifo_empty,
  output logic                pop,
  output logic                underrun,
  output logic                sd,
  output logic                fs_act
);
  localparam int POS_W = $clog2((2**FLD_W) * SAMPLE_W);

  logic [FLD_W-1:0]    k_q, widx_q;
  logic [POS_W-1:0]    pos_q, look_pos;
  logic [SAMPLE_W-1:0] word_q, cur_word;
  logic [FLD_W-1:0]    cur_w_m1;
  logic [BIDX_W-1:0]   bit_idx;
  logic                word_start, last_bit_word, last_word, last_bit_frame;
  logic                step;

  assign step           = run && tick;
  assign word_start     = (k_q == '0);
  assign cur_w_m1       = (widx_q == '0) ? cfg.w0_m1 : cfg.wn_m1;
  assign last_bit_word  = (k_q == cur_w_m1);
  assign last_word      = (widx_q == cfg.words_m1);
  assign last_bit_frame = last_bit_word && last_word;

  assign pop      = step && word_start && !fifo_empty;
  assign underrun = step && word_start && fifo_empty;

  always_comb begin
    if (word_start) cur_word = fifo_empty ? '0 : fifo_dout;
    else            cur_word = word_q;
    bit_idx = cfg.msb_first ? BIDX_W'(cfg.first_bit - k_q)
                            : BIDX_W'(cfg.first_bit + k_q);
    if (cfg.early) look_pos = last_bit_frame ? '0 : pos_q + 1'b1;
    else           look_pos = pos_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      k_q    <= '0;
      widx_q <= '0;
      pos_q  <= '0;
      word_q <= '0;
      sd     <= 1'b0;
      fs_act <= 1'b0;
    end else if (tick) begin
      word_q <= cur_word;
      sd     <= cur_word[bit_idx];
      fs_act <= (look_pos <= POS_W'(cfg.sync_m1));
      k_q    <= last_bit_word ? '0 : k_q + 1'b1;
      if (last_bit_word) widx_q <= last_word ? '0 : widx_q + 1'b1;
      pos_q  <= last_bit_frame ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_en,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             bclk_o,
  output logic             fs_o,
  output logic             sd_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  localparam int LW = $clog2(DEPTH+1);

  logic             tx_en_q, dma_en_q, irq_en_q, err_q;
  logic [DIV_W-1:0] div_q;
  logic             bclk_pol_q, fs_low_q;
  logic [FLD_W-1:0] wm_q;
  frame_cfg_t       fcfg_q;

  logic             wr_ctrl, wr_clk, wr_frame, wr_word, wr_data;
  logic [SAMPLE_W-1:0] fifo_dout;
  logic [LW-1:0]    level;
  logic             fifo_empty, fifo_full, pop, underrun;
  logic             phase, drive_tick, sd_int, fs_act;

  assign wr_ctrl  = cfg_we && (cfg_addr == REG_CTRL);
  assign wr_clk   = cfg_we && (cfg_addr == REG_CLK)   && !tx_en_q;
  assign wr_frame = cfg_we && (cfg_addr == REG_FRAME) && !tx_en_q;
  assign wr_word  = cfg_we && (cfg_addr == REG_WORD)  && !tx_en_q;
  assign wr_data  = cfg_we && (cfg_addr == REG_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q    <= 1'b0;
      dma_en_q   <= 1'b0;
      irq_en_q   <= 1'b0;
      err_q      <= 1'b0;
      div_q      <= '0;
      bclk_pol_q <= 1'b0;
      fs_low_q   <= 1'b0;
      wm_q       <= '0;
      fcfg_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_en_q  <= cfg_wdata[0];
        dma_en_q <= cfg_wdata[1];
        irq_en_q <= cfg_wdata[2];
      end
      if (underrun)                     err_q <= 1'b1;
      else if (wr_ctrl && cfg_wdata[3]) err_q <= 1'b0;
      if (wr_clk) begin
        div_q      <= cfg_wdata[DIV_W-1:0];
        bclk_pol_q <= cfg_wdata[8];
      end
      if (wr_frame) begin
        fcfg_q.words_m1  <= cfg_wdata[4:0];
        fcfg_q.sync_m1   <= cfg_wdata[12:8];
        fcfg_q.early     <= cfg_wdata[16];
        fs_low_q         <= cfg_wdata[17];
        fcfg_q.msb_first <= cfg_wdata[18];
        wm_q             <= cfg_wdata[28:24];
      end
      if (wr_word) begin
        fcfg_q.w0_m1     <= cfg_wdata[4:0];
        fcfg_q.wn_m1     <= cfg_wdata[12:8];
        fcfg_q.first_bit <= cfg_wdata[20:16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
      dma_req_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      cfg_rdata <= '0;
      case (cfg_addr)
        REG_CTRL:  cfg_rdata[3:0] <= {err_q, irq_en_q, dma_en_q, tx_en_q};
        REG_CLK:   cfg_rdata[8:0] <= {bclk_pol_q, div_q};
        REG_FRAME: begin
          cfg_rdata[4:0]   <= fcfg_q.words_m1;
          cfg_rdata[12:8]  <= fcfg_q.sync_m1;
          cfg_rdata[18:16] <= {fcfg_q.msb_first, fs_low_q, fcfg_q.early};
          cfg_rdata[28:24] <= wm_q;
        end
        REG_WORD: begin
          cfg_rdata[4:0]   <= fcfg_q.w0_m1;
          cfg_rdata[12:8]  <= fcfg_q.wn_m1;
          cfg_rdata[20:16] <= fcfg_q.first_bit;
        end
        REG_DATA:  cfg_rdata[LW-1:0] <= level;
        default:   cfg_rdata <= '0;
      endcase
      dma_req_o <= dma_en_q && (level <= LW'(wm_q));
      irq_o     <= err_q && irq_en_q;
    end
  end

  sat_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_data), .din(cfg_wdata), .pop(pop),
    .dout(fifo_dout), .level(level), .empty(fifo_empty), .full(fifo_full)
  );

  sat_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst(rst), .run(tx_en_q), .mclk_en(mclk_en), .div(div_q),
    .phase(phase), .drive_tick(drive_tick)
  );

  sat_framer u_framer (
    .clk(clk), .rst(rst), .run(tx_en_q), .tick(drive_tick), .cfg(fcfg_q),
    .fifo_dout(fifo_dout), .fifo_empty(fifo_empty), .pop(pop),
    .underrun(underrun), .sd(sd_int), .fs_act(fs_act)
  );

  assign bclk_o = phase ^ bclk_pol_q;
  assign fs_o   = fs_act ^ fs_low_q;
  assign sd_o   = sd_int;
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          mclk_en,
  input logic          tx_en,
  input logic          bclk,
  input logic          fs,
  input logic          sd,
  input logic [7:0]    div,
  input logic          drive_tick,
  input logic          underrun,
  input logic          err,
  input logic          irq,
  input logic [LW-1:0] level
);
  // R1: the bit clock moves only on master clock enable cycles while running
  a_r1_bclk_on_mclk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en) && !$stable(bclk)) |-> $past(mclk_en));

  // R3: frame sync moves only on a drive edge while running
  a_r3_fs_on_tick: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en) && !$stable(fs)) |-> $past(drive_tick));

  // R8: divider is frozen while the transmitter is enabled
  a_r8_div_locked: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en)) |-> $stable(div));

  // R6: the fill level never exceeds the depth
  a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R9: an underrun latches the error flag
  a_r9_err_set: assert property (@(posedge clk) disable iff (rst)
    underrun |=> err);

  // R10: the interrupt only follows a set error flag
  a_r10_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(err));

  // R11: serial data is quiet after a disabled cycle
  a_r11_idle_sd: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_en) |-> !sd);
endmodule

bind serial_audio_tx sat_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .mclk_en(mclk_en), .tx_en(tx_en_q), .bclk(bclk_o),
  .fs(fs_o), .sd(sd_o), .div(div_q), .drive_tick(drive_tick),
  .underrun(underrun), .err(err_q), .irq(irq_o), .level(level)
);

// File: tb/serial_audio_tx_test.sv
`timescale 1ns/1ps
module serial_audio_tx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mclk_en = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bclk_o, fs_o, sd_o, dma_req_o, irq_o;

  serial_audio_tx uut (
    .clk(clk), .rst(rst), .mclk_en(mclk_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bclk_o(bclk_o), .fs_o(fs_o), .sd_o(sd_o), .dma_req_o(dma_req_o),
    .irq_o(irq_o)
  );

  initial forever #2.5 clk = ~clk;

  logic mclk_half = 1'b0;
  initial forever begin
    @(negedge clk);
    mclk_en = mclk_half ? ~mclk_en : 1'b1;
  end

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // shadow of the programmed configuration
  int b_div, b_pol, b_wm1, b_sm1, b_early, b_fslow, b_msb, b_w0, b_wn, b_first;
  logic [31:0] pushed [0:63];
  int npush;
  logic cap_sd [0:255];
  logic cap_fs [0:255];
  int   cap_t  [0:255];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 3'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic push(input logic [31:0] v);
    wr(4, v);
    if (npush < 64) pushed[npush] = v;
    npush++;
  endtask

  task automatic do_reset();
    rst = 1'b1; npush = 0; mclk_half = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic program_link();
    wr(1, 32'(b_div) | (32'(b_pol) << 8));
    wr(2, 32'(b_wm1) | (32'(b_sm1) << 8) | (32'(b_early) << 16) |
          (32'(b_fslow) << 17) | (32'(b_msb) << 18));
    wr(3, 32'(b_w0) | (32'(b_wn) << 8) | (32'(b_first) << 16));
  endtask

  task automatic capture(input int n);
    int cnt = 0;
    int cyc = 0;
    logic prevb = bclk_o;
    while (cnt < n && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prevb != 1'(b_pol) && bclk_o == 1'(b_pol)) begin
        cap_sd[cnt] = sd_o; cap_fs[cnt] = fs_o; cap_t[cnt] = cyc;
        cnt++;
      end
      prevb = bclk_o;
    end
    chk(cnt == n, "R1", "drive edges seen", cnt, n);
  endtask

  // expected stream built from the requirements
  task automatic compare(input int n, input string req);
    int widx = 0, k = 0, pos = 0, wcnt = 0, flen, wm1, bi, q;
    logic [31:0] cur = '0;
    logic esd, efs;
    int bad_sd = 0, bad_fs = 0;
    flen = (b_w0 + 1) + b_wm1 * (b_wn + 1);
    for (int i = 0; i < n; i++) begin
      if (k == 0) begin
        cur = (wcnt < npush) ? pushed[wcnt] : 32'h0;
        wcnt++;
      end
      wm1 = (widx == 0) ? b_w0 : b_wn;
      bi  = b_msb ? ((b_first - k) & 31) : ((b_first + k) & 31);
      esd = cur[bi];
      q   = b_early ? ((pos + 1) % flen) : pos;
      efs = 1'((q <= b_sm1) ? 1 : 0) ^ 1'(b_fslow);
      if (cap_sd[i] !== esd) begin
        bad_sd++;
        chk(0, req, $sformatf("sd bit %0d", i), cap_sd[i], esd);
      end
      if (cap_fs[i] !== efs) begin
        bad_fs++;
        chk(0, "R3", $sformatf("fs bit %0d", i), cap_fs[i], efs);
      end
      pos = (pos + 1) % flen;
      if (k == wm1) begin
        k = 0;
        widx = (widx == b_wm1) ? 0 : widx + 1;
      end else k++;
    end
    chk(bad_sd == 0, req, "data stream", bad_sd, 0);
    chk(bad_fs == 0, "R3", "sync stream", bad_fs, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk(d == 0, "R12", $sformatf("reg %0d after reset", a), d, 0);
    end
    chk({bclk_o, fs_o, sd_o, dma_req_o, irq_o} == 5'b0, "R12", "outputs after reset",
        {bclk_o, fs_o, sd_o, dma_req_o, irq_o}, 0);
  endtask

  task automatic t_period();
    do_reset();
    b_div = 3; b_pol = 0; b_wm1 = 1; b_sm1 = 0; b_early = 0; b_fslow = 0;
    b_msb = 1; b_w0 = 7; b_wn = 7; b_first = 7;
    program_link();
    wr(0, 1);
    capture(3);
    chk(cap_t[2] - cap_t[1] == 8, "R1", "period div 3", cap_t[2] - cap_t[1], 8);
    wr(0, 0);
    b_div = 2; program_link();
    mclk_half = 1'b1;
    wr(0, 1);
    capture(3);
    chk(cap_t[2] - cap_t[1] == 12, "R1", "period div 2 half-rate enable",
        cap_t[2] - cap_t[1], 12);
    mclk_half = 1'b0;
  endtask

  task automatic t_stereo();
    do_reset();
    b_div = 0; b_pol = 0; b_wm1 = 1; b_sm1 = 23; b_early = 0; b_fslow = 1;
    b_msb = 1; b_w0 = 23; b_wn = 23; b_first = 31;
    program_link();
    push(32'hA5C3_0F00); push(32'h1234_5600); push(32'hFFEE_DD00); push(32'h0F1E_2D00);
    wr(0, 1);
    capture(96);
    compare(96, "R2");
  endtask

  task automatic t_early_lsb();
    logic [31:0] d;
    do_reset();
    b_div = 1; b_pol = 1; b_wm1 = 2; b_sm1 = 2; b_early = 1; b_fslow = 0;
    b_msb = 0; b_w0 = 7; b_wn = 3; b_first = 4;
    program_link();
    chk(bclk_o == 1'b1, "R1", "idle level with polarity set", bclk_o, 1);
    push(32'h0000_1B70); push(32'h0000_00A0); push(32'h0000_0150);
    push(32'h0000_0FF0); push(32'h0000_0060); push(32'h0000_0190);
    push(32'h0000_0333);
    wr(0, 1);
    capture(32);
    compare(32, "R5");
    chk(cap_fs[15] == 1'b1, "R4", "sync on last bit of frame", cap_fs[15], 1);
    wr(0, 0);
    repeat (4) @(negedge clk);
    chk(bclk_o == 1'b1 && sd_o == 1'b0 && fs_o == 1'b0, "R11", "idle outputs",
        {bclk_o, sd_o, fs_o}, 3'b100);
    rd(4, d);
    chk(d == 1, "R11", "fifo kept while disabled", d, 1);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    do_reset();
    b_div = 0; b_pol = 0; b_wm1 = 1; b_sm1 = 7; b_early = 0; b_fslow = 0;
    b_msb = 1; b_w0 = 7; b_wn = 7; b_first = 7;
    program_link();
    push(32'h0000_00B6);
    wr(0, 5);
    capture(32);
    compare(32, "R9");
    rd(0, d);
    chk(d == 13, "R9", "error flag set", d, 13);
    chk(irq_o == 1'b1, "R10", "irq raised", irq_o, 1);
    wr(0, 4);
    rd(0, d);
    chk(d == 12, "R10", "writing 0 keeps flag", d, 12);
    wr(0, 12);
    rd(0, d);
    chk(d == 4, "R10", "write 1 clears flag", d, 4);
    chk(irq_o == 1'b0, "R10", "irq dropped", irq_o, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    wr(1, 3);
    wr(0, 1);
    wr(1, 32'h1FF);
    wr(2, 32'h0007_1F1F);
    rd(1, d);
    chk(d == 3, "R8", "clock reg locked", d, 3);
    rd(2, d);
    chk(d == 0, "R8", "frame reg locked", d, 0);
    wr(0, 0);
    wr(1, 32'h1FF);
    rd(1, d);
    chk(d == 32'h1FF, "R8", "clock reg writable when stopped", d, 32'h1FF);
  endtask

  task automatic t_fifo_dma();
    logic [31:0] d;
    do_reset();
    wr(2, 32'h0400_0000);
    chk(dma_req_o == 1'b0, "R7", "no request while disabled", dma_req_o, 0);
    wr(0, 2);
    @(negedge clk);
    chk(dma_req_o == 1'b1, "R7", "request at level 0", dma_req_o, 1);
    for (int i = 0; i < 4; i++) push(32'(i));
    @(negedge clk);
    chk(dma_req_o == 1'b1, "R7", "request at watermark", dma_req_o, 1);
    push(32'h55);
    @(negedge clk);
    chk(dma_req_o == 1'b0, "R7", "no request above watermark", dma_req_o, 0);
    rd(4, d);
    chk(d == 5, "R6", "level after five pushes", d, 5);
    for (int i = 0; i < 29; i++) push(32'(i));
    rd(4, d);
    chk(d == 32, "R6", "full fifo drops pushes", d, 32);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_period();
    t_stereo();
    t_early_lsb();
    t_underrun();
    t_lock();
    t_fifo_dma();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule